// File: doc/BRIEF.md
# Banked Memory Bus with Device Selection

This block is a shared byte-wide bus that lets one controller reach up to four plug-in devices. The controller presents a 2-bit device code, an 8-bit address, a global access enable and two separate strobes, one for read and one for write. A decoder turns the code into one per-slot read line and one per-slot write line. Each line is active only while the access enable is high, the code matches that slot, and the matching strobe is high.

Slot 0 is a general bank. It holds RAM, a pair of input bytes that sample external switches, and a pair of output bytes that drive external actuators. Slot 1 is a read-only register set with no write path. Slot 2 is left empty. Slot 3 is a 512-pixel monochrome frame store.

Reads are combinational from the selected device. Writes land on the rising clock edge. The read bus returns 0x00 whenever no device answers.

Top module: `membus_top`

## Requirements
- R1: A device answers a read or accepts a write only when `dev_sel` equals its code: 00 for the general bank, 01 for the read-only registers, 11 for the frame store. Code 10 has no device.
- R2: A write takes effect at the rising clock edge on which `acc_en`, `wr_en` and a matching code are all high. At most one slot is write-strobed in any cycle.
- R3: While `acc_en` is low, `rdata` is 0x00 and no storage or output byte changes, whatever `rd_en` and `wr_en` are.
- R4: General-bank addresses 0x00 to 0x3F are RAM. A read returns the last byte written there, or 0x00 after reset.
- R5: General-bank addresses 0xF0 and 0xF1 read input bytes 0 and 1 of `gpi_pins` (byte 0 is bits 7:0). Writes to these addresses change nothing.
- R6: General-bank addresses 0xF2 and 0xF3 hold output bytes 0 and 1, driven on `gpo_pins` (byte 0 is bits 7:0). These bytes are 0x00 after reset, and a read returns the last value written.
- R7: Frame-store addresses 0x00 to 0x3F hold 512 pixels, 8 per byte, and read back the last byte written, or 0x00 after reset. Frame-store addresses 0x40 and above read 0x00, and writes to them are ignored.
- R8: A read-only register read returns `addr ^ 8'h5A`. Writes to slot 01 change nothing.
- R9: `rdata` is 0x00 when `rd_en` is low, when code 10 is selected, or when a general-bank address lies outside RAM and both I/O windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 2 | Device code |
| addr | input | 8 | Byte address inside the selected device |
| acc_en | input | 1 | Global access enable |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when nothing answers |
| gpi_pins | input | 16 | Two external input bytes |
| gpo_pins | output | 16 | Two output bytes to actuators |

## Verification
Some faults can only be seen through the read port. A decode or gating fault that lets a write reach the wrong slot, or land while the enable is low, corrupts stored bytes without any sign at the time. It shows up only on a later read of that address, so each write scenario is followed by read-backs of the target address and of neighbouring slots and windows. The output bytes are the exception: a stray write to them appears on `gpo_pins` one clock after the edge. Read-path faults, such as a wrong mux leg, a missing zero default or a swapped input byte, appear on `rdata` in the same cycle the address is applied.

// File: rtl/membus_pkg.sv
package membus_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NSLOT = 4;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  localparam logic [1:0] SLOT_GEN = 2'b00;
  localparam logic [1:0] SLOT_RO  = 2'b01;
  localparam logic [1:0] SLOT_FB  = 2'b11;

  function automatic logic in_window(addr_t a, addr_t base, addr_t cnt);
    return (a >= base) && (a < base + cnt);
  endfunction

  function automatic byte_t ro_value(addr_t a);
    return a ^ 8'h5A;
  endfunction
endpackage

// File: rtl/bus_decode.sv
module bus_decode
  import membus_pkg::*;
(
  input  logic [1:0]       dev_sel,
  input  logic             acc_en,
  input  logic             rd_en,
  input  logic             wr_en,
  output logic [NSLOT-1:0] slot_rd,
  output logic [NSLOT-1:0] slot_wr
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    assign hit        = acc_en && (dev_sel == 2'(g));
    assign slot_rd[g] = hit && rd_en;
    assign slot_wr[g] = hit && wr_en;
  end
endmodule

// File: rtl/gen_bank.sv
module gen_bank
  import membus_pkg::*;
#(
  parameter int    RAM_DEPTH = 64,
  parameter int    GPI_N     = 2,
  parameter int    GPO_N     = 2,
  parameter addr_t GPI_BASE  = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  addr_t            addr,
  input  byte_t            wdata,
  input  logic [GPI_N*8-1:0] gpi_pins,
  output logic [GPO_N*8-1:0] gpo_pins,
  output byte_t            rd_byte
);
  localparam int    RAW      = $clog2(RAM_DEPTH);
  localparam addr_t RAM_TOP  = addr_t'(RAM_DEPTH);
  localparam addr_t GPO_BASE = GPI_BASE + addr_t'(GPI_N);

  byte_t ram [RAM_DEPTH];
  byte_t gpo_q [GPO_N];
  logic  ram_hit;
  assign ram_hit = addr < RAM_TOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
      for (int i = 0; i < GPO_N; i++) gpo_q[i] <= '0;
    end else if (wr) begin
      if (ram_hit) ram[addr[RAW-1:0]] <= wdata;
      for (int i = 0; i < GPO_N; i++)
        if (addr == GPO_BASE + addr_t'(i)) gpo_q[i] <= wdata;
    end
  end

  for (genvar g = 0; g < GPO_N; g++) begin : g_gpo
    assign gpo_pins[g*8 +: 8] = gpo_q[g];
  end

  always_comb begin
    rd_byte = '0;
    if (ram_hit) rd_byte = ram[addr[RAW-1:0]];
    for (int i = 0; i < GPI_N; i++)
      if (addr == GPI_BASE + addr_t'(i)) rd_byte = gpi_pins[i*8 +: 8];
    for (int i = 0; i < GPO_N; i++)
      if (addr == GPO_BASE + addr_t'(i)) rd_byte = gpo_q[i];
  end
endmodule

// File: rtl/frame_store.sv
module frame_store
  import membus_pkg::*;
#(
  parameter int PIXELS = 512
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  addr_t addr,
  input  byte_t wdata,
  output byte_t rd_byte
);
  localparam int    NBYTES = PIXELS / DW;
  localparam int    FAW    = $clog2(NBYTES);
  localparam addr_t TOP    = addr_t'(NBYTES);

  byte_t fb [NBYTES];
  logic  hit;
  assign hit = addr < TOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) fb[i] <= '0;
    end else if (wr && hit) begin
      fb[addr[FAW-1:0]] <= wdata;
    end
  end

  assign rd_byte = hit ? fb[addr[FAW-1:0]] : '0;
endmodule

// File: rtl/membus_top.sv
module membus_top
  import membus_pkg::*;
#(
  parameter int    RAM_DEPTH = 64,
  parameter int    GPI_N     = 2,
  parameter int    GPO_N     = 2,
  parameter addr_t GPI_BASE  = 8'hF0,
  parameter int    PIXELS    = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         dev_sel,
  input  logic [7:0]         addr,
  input  logic               acc_en,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [GPI_N*8-1:0] gpi_pins,
  output logic [GPO_N*8-1:0] gpo_pins
);
  logic [NSLOT-1:0] dev_rd;
  logic [NSLOT-1:0] dev_wr;
  byte_t gen_byte, fb_byte, ro_byte;

  bus_decode u_dec (
    .dev_sel(dev_sel), .acc_en(acc_en), .rd_en(rd_en), .wr_en(wr_en),
    .slot_rd(dev_rd), .slot_wr(dev_wr)
  );

  gen_bank #(
    .RAM_DEPTH(RAM_DEPTH), .GPI_N(GPI_N), .GPO_N(GPO_N), .GPI_BASE(GPI_BASE)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .wr(dev_wr[SLOT_GEN]), .addr(addr),
    .wdata(wdata), .gpi_pins(gpi_pins), .gpo_pins(gpo_pins), .rd_byte(gen_byte)
  );

  frame_store #(.PIXELS(PIXELS)) u_fb (
    .clk(clk), .rst_n(rst_n), .wr(dev_wr[SLOT_FB]), .addr(addr),
    .wdata(wdata), .rd_byte(fb_byte)
  );

  assign ro_byte = ro_value(addr);

  always_comb begin
    rdata = '0;
    if (dev_rd[SLOT_GEN]) rdata = gen_byte;
    if (dev_rd[SLOT_RO])  rdata = ro_byte;
    if (dev_rd[SLOT_FB])  rdata = fb_byte;
  end
endmodule

// File: rtl/membus_chk.sv
module membus_chk #(
  parameter int         GPI_N    = 2,
  parameter int         GPO_N    = 2,
  parameter logic [7:0] GPI_BASE = 8'hF0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_en,
  input logic [7:0]         addr,
  input logic [7:0]         rdata,
  input logic [GPI_N*8-1:0] gpi_pins,
  input logic [GPO_N*8-1:0] gpo_pins,
  input logic [3:0]         dev_rd,
  input logic [3:0]         dev_wr
);
  localparam logic [7:0] GPO_BASE = GPI_BASE + 8'(GPI_N);

  logic gpo_touch;
  logic gpi_hit;
  logic [7:0] gpi_exp;
  always_comb begin
    gpo_touch = 1'b0;
    gpi_hit   = 1'b0;
    gpi_exp   = '0;
    for (int i = 0; i < GPO_N; i++)
      if (dev_wr[0] && addr == GPO_BASE + 8'(i)) gpo_touch = 1'b1;
    for (int i = 0; i < GPI_N; i++)
      if (addr == GPI_BASE + 8'(i)) begin
        gpi_hit = 1'b1;
        gpi_exp = gpi_pins[i*8 +: 8];
      end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_wr)); // R2
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (dev_wr == 4'b0) && (rdata == 8'h00)); // R3
  AST_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gpo_touch |=> $stable(gpo_pins)); // R6
  AST_GPI_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd[0] && gpi_hit) |-> rdata == gpi_exp); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd == 4'b0) |-> rdata == 8'h00); // R9
  AST_RO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd[1] |-> rdata == (addr ^ 8'h5A)); // R8
endmodule

bind membus_top membus_chk #(
  .GPI_N(GPI_N), .GPO_N(GPO_N), .GPI_BASE(GPI_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .addr(addr), .rdata(rdata),
  .gpi_pins(gpi_pins), .gpo_pins(gpo_pins), .dev_rd(dev_rd), .dev_wr(dev_wr)
);

// File: tb/sim_membus_top.sv
module sim_membus_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] dev_sel = 2'b00;
  logic [7:0] addr = 8'h00;
  logic       acc_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [15:0] gpi_pins = 16'h0000;
  logic [15:0] gpo_pins;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  membus_top u0 (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .addr(addr),
    .acc_en(acc_en), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .gpi_pins(gpi_pins), .gpo_pins(gpo_pins)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] s, logic [7:0] a, logic [7:0] d, logic en = 1'b1);
    @(negedge clk);
    dev_sel = s; addr = a; wdata = d; acc_en = en; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; acc_en = 1'b0;
  endtask

  task automatic bus_rd(string req, logic [1:0] s, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    dev_sel = s; addr = a; acc_en = 1'b1; rd_en = 1'b1; wr_en = 1'b0;
    #2;
    check(req, {8'h00, rdata}, {8'h00, exp});
    rd_en = 1'b0; acc_en = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd("R4 reset ram", 2'b00, 8'h05, 8'h00);
    bus_rd("R7 reset fb", 2'b11, 8'h3F, 8'h00);
    check("R6 reset gpo", gpo_pins, 16'h0000);
  endtask

  task automatic t_ram;
    bus_wr(2'b00, 8'h00, 8'h11);
    bus_wr(2'b00, 8'h3F, 8'hC3);
    bus_rd("R4 ram low", 2'b00, 8'h00, 8'h11);
    bus_rd("R4 ram top", 2'b00, 8'h3F, 8'hC3);
    bus_rd("R1 ram not in fb", 2'b11, 8'h3F, 8'h00);
    bus_rd("R9 gap addr", 2'b00, 8'h40, 8'h00);
  endtask

  task automatic t_gpi;
    gpi_pins = 16'hB27E;
    bus_rd("R5 gpi byte0", 2'b00, 8'hF0, 8'h7E);
    bus_rd("R5 gpi byte1", 2'b00, 8'hF1, 8'hB2);
    bus_wr(2'b00, 8'hF0, 8'h00);
    bus_rd("R5 gpi write ignored", 2'b00, 8'hF0, 8'h7E);
    check("R5 gpi write no gpo", gpo_pins, 16'h0000);
  endtask

  task automatic t_gpo;
    bus_wr(2'b00, 8'hF2, 8'h5C);
    check("R6 gpo byte0 pins", gpo_pins, 16'h005C);
    bus_wr(2'b00, 8'hF3, 8'hA1);
    check("R6 gpo byte1 pins", gpo_pins, 16'hA15C);
    bus_rd("R6 gpo readback", 2'b00, 8'hF3, 8'hA1);
  endtask

  task automatic t_fb;
    for (int i = 0; i < 4; i++) bus_wr(2'b11, 8'(i * 21), 8'(8'h30 + i));
    for (int i = 0; i < 4; i++) bus_rd("R7 fb readback", 2'b11, 8'(i * 21), 8'(8'h30 + i));
    bus_wr(2'b11, 8'h40, 8'hEE);
    bus_rd("R7 fb out of range", 2'b11, 8'h40, 8'h00);
    bus_rd("R7 fb alias untouched", 2'b11, 8'h00, 8'h30);
    bus_rd("R1 fb not in ram", 2'b00, 8'h00, 8'h11);
  endtask

  task automatic t_ro;
    bus_rd("R8 ro a", 2'b01, 8'h00, 8'h5A);
    bus_rd("R8 ro b", 2'b01, 8'hC3, 8'h99);
    bus_wr(2'b01, 8'h00, 8'hFF);
    bus_rd("R8 ro after write", 2'b01, 8'h00, 8'h5A);
    bus_rd("R8 ro write no ram", 2'b00, 8'h00, 8'h11);
  endtask

  task automatic t_empty;
    bus_wr(2'b10, 8'h00, 8'h77);
    bus_rd("R9 empty slot", 2'b10, 8'h00, 8'h00);
    bus_rd("R1 empty slot no ram", 2'b00, 8'h00, 8'h11);
    bus_rd("R1 empty slot no fb", 2'b11, 8'h00, 8'h30);
    @(negedge clk);
    dev_sel = 2'b00; addr = 8'h00; acc_en = 1'b1; rd_en = 1'b0;
    #2 check("R9 rd_en low", {8'h00, rdata}, 16'h0000);
    acc_en = 1'b0;
  endtask

  task automatic t_enable_off;
    bus_wr(2'b00, 8'h00, 8'hDD, 1'b0);
    bus_wr(2'b00, 8'hF2, 8'hDD, 1'b0);
    bus_wr(2'b11, 8'h00, 8'hDD, 1'b0);
    check("R3 gpo kept", gpo_pins, 16'hA15C);
    @(negedge clk);
    dev_sel = 2'b00; addr = 8'h00; acc_en = 1'b0; rd_en = 1'b1;
    #2 check("R3 rdata idle", {8'h00, rdata}, 16'h0000);
    rd_en = 1'b0;
    bus_rd("R3 ram kept", 2'b00, 8'h00, 8'h11);
    bus_rd("R3 fb kept", 2'b11, 8'h00, 8'h30);
    bus_wr(2'b00, 8'h10, 8'h42);
    bus_rd("R2 write lands", 2'b00, 8'h10, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ram();
    t_gpi();
    t_gpo();
    t_fb();
    t_ro();
    t_empty();
    t_enable_off();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule